// File: doc/BRIEF.md
# Serial Register Access Port with Burst

This block is a serial slave that gives an external host read and write access to a small register file inside the chip. The host lowers chip select, shifts in a command byte, then shifts data bytes in (write) or out (read). Both the command and the data bytes travel least-significant bit first. Two static select inputs choose the serial clock edge on which input data is captured and the edge on which output data is launched. Each choice is made independently of the other.

The command byte carries three fields: a direction bit, a register address and a burst flag. One bit in it is reserved. A burst ignores the address and walks the registers upward from address zero. A read burst ends after register 0x15. A write burst accepts registers up to and including 0x16. All serial pins are sampled by the block's own system clock through synchronizers, so the host may access the port at any time, with no relation to the system clock. The rest of the chip reads the register contents through a combinational local read port.

Top module: `serial_regport`

## Requirements
- R1: Whenever chip select (`cs_n`) is high, the transfer is abandoned and the control logic returns to idle. `sdo_oe` is low no later than 3 system clocks after `cs_n` rises, and it stays low while `cs_n` is high.
- R2: The command byte is received LSB first. Bit 0 is the direction (1 = read, 0 = write), bits 1 to 5 are the register address, bit 6 is reserved, and bit 7 is the burst flag. A non-burst access touches only the addressed register.
- R3: A non-burst write stores the next 8 bits, received LSB first, into the addressed register.
- R4: A non-burst read sends the addressed register LSB first, one bit per launch edge after the command byte. `sdo_oe` is high only while read data is being driven.
- R5: With `in_edge_sel` = 0, input bits are captured on rising `sclk` edges. With `in_edge_sel` = 1, they are captured on falling edges.
- R6: With `out_edge_sel` = 0, output bits change on falling `sclk` edges. With `out_edge_sel` = 1, they change on rising edges. Each output bit holds until the next launch edge.
- R7: A burst read ignores the address field. It sends registers 0x00 through 0x15 in ascending order. On the launch edge that follows the last bit of 0x15, the output turns off.
- R8: A burst write ignores the address field. It writes registers 0x00 through 0x16 in ascending order, and any further bytes are ignored.
- R9: In a non-burst access, clocks after the single data byte have no effect. No second register is written, and no further data is driven.
- R10: A register is written only after all 8 data bits have arrived. A byte cut short by `cs_n` rising leaves the register unchanged.
- R11: A command byte with bit 6 set causes the whole transfer to be ignored. Nothing is written, and `sdo_oe` stays low until `cs_n` rises.
- R12: `lcl_rdata` always shows the current contents of the register selected by `lcl_addr`.
- R13: After reset every register reads 0x00 and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; asynchronous to `clk` |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| in_edge_sel | input | 1 | 0: capture on rising `sclk`; 1: capture on falling `sclk` |
| out_edge_sel | input | 1 | 0: launch on falling `sclk`; 1: launch on rising `sclk` |
| sdo_d | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo_d`; low means high-impedance |
| lcl_addr | input | ADDR_W | Local read address |
| lcl_rdata | output | DATA_W | Local read data |

## Verification
The bench uses the defaults: a 5-bit address, 8-bit data, two synchronizer stages, and burst limits of 0x15 for reads and 0x16 for writes. These values make the full 32-entry address space and both asymmetric burst ends reachable, and a serial bit period of 16 system clocks leaves room for the synchronizer latency. With these values, the bench runs all four capture and launch edge pairings. It also runs a burst write that overruns its last register by one byte, a burst read whose address field is nonzero, and transfers cut off in the middle of a byte.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the serial register port.
// Holds the control state encoding and the fixed bit position of the
// direction flag in the command byte. The other field positions follow
// from the address width and are derived in the controller.
package sp_pkg;

    typedef enum logic [2:0] {
        ST_CMD,   // collecting the command byte
        ST_WR,    // collecting write data bytes
        ST_RD,    // driving read data bytes
        ST_END,   // access finished, waiting for chip select to rise
        ST_IGN    // reserved command, transfer ignored
    } sp_state_t;

    localparam int CMD_DIR_POS = 0;    // 1 = read, 0 = write
    localparam int CMD_ADDR_POS = 1;   // address field starts here

endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
// Module: sp_sync
// Multi-bit level synchronizer. Each bit of async_i passes through
// STAGES flops clocked by clk. It assumes the inputs are independent
// slow levels, so every bit arrives with the same latency of STAGES
// cycles. Each bit has its own reset value.
module sp_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first capture flop of every bit
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                // further metastability filtering stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign level_o = chain[STAGES-1];

endmodule

// File: rtl/sp_edge.sv
`timescale 1ns/1ps
// Module: sp_edge
// Edge detector for a synchronized level. rise_o and fall_o each pulse
// for one clk cycle in the cycle where level_i is first seen changed.
// It assumes level_i is already synchronous to clk.
module sp_edge #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev;

    // remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_VAL;
        else        prev <= level_i;
    end

    assign rise_o = level_i & ~prev;
    assign fall_o = ~level_i & prev;

endmodule

// File: rtl/sp_regfile.sv
`timescale 1ns/1ps
// Module: sp_regfile
// Register file with one synchronous write port and two combinational
// read ports. One read port is for the serial controller and one is for
// the local logic. Every entry resets to zero. It assumes at most one
// write per cycle.
module sp_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // clear on reset, otherwise store one byte per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/sp_ctrl.sv
`timescale 1ns/1ps
// Module: sp_ctrl
// Serial transfer controller. It decodes the LSB-first command byte,
// collects write bytes, and launches read bits. It also sequences burst
// addresses up to separate read and write limits. All inputs are
// synchronous to clk. sample_ev and launch_ev are single-cycle event
// pulses, and both are already gated by chip select. Whenever cs_act is
// low, the controller holds its idle state.
module sp_ctrl
    import sp_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int RD_LAST = 21,
    parameter int WR_LAST = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sample_ev,
    input  logic              launch_ev,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] rf_raddr,
    output logic              sdo_d,
    output logic              sdo_oe,
    output sp_state_t         state_o,
    output logic              burst_o
);

    localparam int CMD_W = ADDR_W + 3;
    localparam int CMD_RSV_POS = ADDR_W + 1;
    localparam int CMD_BURST_POS = ADDR_W + 2;
    localparam int MAX_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] TX_DONE = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [ADDR_W-1:0] RD_END = ADDR_W'(RD_LAST);
    localparam logic [ADDR_W-1:0] WR_END = ADDR_W'(WR_LAST);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    sp_state_t         state;
    logic [CMD_W-1:0]  cmd_sh;
    logic [CMD_W-1:0]  cmd_next;
    logic [DATA_W-1:0] dat_sh;
    logic [DATA_W-1:0] dat_next;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  tx_idx;
    logic [ADDR_W-1:0] addr;
    logic              burst;

    // next shift contents with the new bit entering at the top (LSB first)
    always_comb begin
        cmd_next = {sdi_s, cmd_sh[CMD_W-1:1]};
        dat_next = {sdi_s, dat_sh[DATA_W-1:1]};
    end

    // write strobe on the capture of a byte's last bit; read address looks ahead at byte end
    always_comb begin
        rf_we    = cs_act && sample_ev && (state == ST_WR) && (bit_cnt == DAT_LAST);
        rf_waddr = addr;
        rf_wdata = dat_next;
        rf_raddr = (tx_idx == TX_DONE) ? (addr + ADDR_ONE) : addr;
    end

    // transfer sequencing: command decode, data capture, bit launch
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            state   <= ST_CMD;
            cmd_sh  <= '0;
            dat_sh  <= '0;
            bit_cnt <= '0;
            tx_idx  <= '0;
            addr    <= '0;
            burst   <= 1'b0;
            sdo_d   <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            case (state)
                ST_CMD: begin
                    if (sample_ev) begin
                        cmd_sh <= cmd_next;
                        if (bit_cnt == CMD_LAST) begin
                            bit_cnt <= '0;
                            burst   <= cmd_next[CMD_BURST_POS];
                            addr    <= cmd_next[CMD_BURST_POS] ? '0
                                       : cmd_next[CMD_ADDR_POS +: ADDR_W];
                            if (cmd_next[CMD_RSV_POS])      state <= ST_IGN;
                            else if (cmd_next[CMD_DIR_POS]) state <= ST_RD;
                            else                            state <= ST_WR;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end
                    end
                end
                ST_WR: begin
                    if (sample_ev) begin
                        dat_sh <= dat_next;
                        if (bit_cnt == DAT_LAST) begin
                            bit_cnt <= '0;
                            if (burst && (addr != WR_END)) addr <= addr + ADDR_ONE;
                            else                           state <= ST_END;
                        end else begin
                            bit_cnt <= bit_cnt + CNT_ONE;
                        end
                    end
                end
                ST_RD: begin
                    if (launch_ev) begin
                        if (tx_idx != TX_DONE) begin
                            sdo_d  <= rf_rdata[tx_idx[IDX_W-1:0]];
                            sdo_oe <= 1'b1;
                            tx_idx <= tx_idx + CNT_ONE;
                        end else if (burst && (addr != RD_END)) begin
                            addr   <= addr + ADDR_ONE;
                            sdo_d  <= rf_rdata[0];
                            tx_idx <= CNT_ONE;
                        end else begin
                            state  <= ST_END;
                            sdo_oe <= 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign state_o = state;
    assign burst_o = burst;

endmodule

// File: rtl/serial_regport.sv
`timescale 1ns/1ps
// Module: serial_regport
// Top level of the serial register access port. It synchronizes chip
// select, serial clock and serial data into clk. It turns the selected
// serial clock edges into capture and launch events, and drives the
// controller and the register file. It assumes clk runs several times
// faster than sclk; at least 2*SYNC_STAGES+2 clk cycles per sclk phase
// are needed so each bit is seen.
module serial_regport
    import sp_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RD_LAST = 21,
    parameter int WR_LAST = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              in_edge_sel,
    input  logic              out_edge_sel,
    output logic              sdo_d,
    output logic              sdo_oe,
    input  logic [ADDR_W-1:0] lcl_addr,
    output logic [DATA_W-1:0] lcl_rdata
);

    localparam int SYNC_W = 3;
    localparam logic [SYNC_W-1:0] SYNC_RST = 3'b100;  // chip select idles high

    logic [SYNC_W-1:0] pins_s;
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              sample_ev;
    logic              launch_ev;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;
    logic [ADDR_W-1:0] rf_raddr;
    logic [DATA_W-1:0] rf_rdata;
    sp_state_t         ctrl_state;
    logic              ctrl_burst;

    sp_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, sdi}),
        .level_o (pins_s)
    );

    sp_edge #(
        .IDLE_VAL (1'b0)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pins_s[1]),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    // map the static edge selects onto capture and launch events
    always_comb begin
        cs_act    = ~pins_s[2];
        sample_ev = cs_act & (in_edge_sel ? sclk_fall : sclk_rise);
        launch_ev = cs_act & (out_edge_sel ? sclk_rise : sclk_fall);
    end

    sp_ctrl #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RD_LAST (RD_LAST),
        .WR_LAST (WR_LAST)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sample_ev (sample_ev),
        .launch_ev (launch_ev),
        .sdi_s     (pins_s[0]),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .rf_raddr  (rf_raddr),
        .sdo_d     (sdo_d),
        .sdo_oe    (sdo_oe),
        .state_o   (ctrl_state),
        .burst_o   (ctrl_burst)
    );

    sp_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (rf_raddr),
        .rdata_a (rf_rdata),
        .raddr_b (lcl_addr),
        .rdata_b (lcl_rdata)
    );

endmodule

// File: rtl/sp_checker.sv
`timescale 1ns/1ps
// Module: sp_checker
// Property checker for serial_regport, attached by bind. It watches the
// chip select pin, the output pins, the launch event and the
// controller's state and write port.
module sp_checker
    import sp_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WR_LAST = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo_d,
    input logic              sdo_oe,
    input logic              launch_ev,
    input sp_state_t         state,
    input logic              rf_we,
    input logic [ADDR_W-1:0] rf_waddr,
    input logic              burst
);

    // R1: chip select high for three cycles leaves the output off
    assert_hiz_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

    // R4: output is enabled only while read data is driven
    assert_oe_read_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (state == ST_RD));

    // R6: an enabled bit changes only right after a launch event
    assert_bit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(launch_ev)) |-> $stable(sdo_d));

    // R8: burst writes never pass the write limit
    assert_burst_wr_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && burst) |-> (rf_waddr <= ADDR_W'(WR_LAST)));

    // R11: an ignored transfer never writes and never drives
    assert_ignore_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGN) |-> (!sdo_oe && !rf_we));

endmodule

bind serial_regport sp_checker #(
    .ADDR_W  (ADDR_W),
    .WR_LAST (WR_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sdo_d     (sdo_d),
    .sdo_oe    (sdo_oe),
    .launch_ev (launch_ev),
    .state     (ctrl_state),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .burst     (ctrl_burst)
);

// File: tb/serial_regport_test.sv
`timescale 1ns/1ps
// Bench for serial_regport. It models the host behaviourally: it counts
// serial edges to find command completion and launch edges, keeps the
// expected register contents in an array, and checks the output enable
// on every clock.
module serial_regport_test;

    localparam int AW = 5;
    localparam int DW = 8;
    localparam int NREG = 32;
    localparam int H = 8;   // system clocks per sclk phase

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic ices = 1'b0;
    logic oces = 1'b0;
    logic sdo_d;
    logic sdo_oe;
    logic [AW-1:0] lcl_addr = '0;
    logic [DW-1:0] lcl_rdata;

    always #2.5 clk = ~clk;

    serial_regport #(
        .ADDR_W (AW), .DATA_W (DW), .SYNC_STAGES (2), .RD_LAST (21), .WR_LAST (22)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .sdi (sdi),
        .in_edge_sel (ices), .out_edge_sel (oces), .sdo_d (sdo_d), .sdo_oe (sdo_oe),
        .lcl_addr (lcl_addr), .lcl_rdata (lcl_rdata)
    );

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] exp_regs [NREG];
    logic [DW-1:0] wbuf [32];
    logic rx_bit [$];
    logic rx_oe [$];
    int samp_cnt;
    bit cmd_done;
    bit quiet_mode = 1'b0;
    int cs_hi_cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one sclk edge; record the output after each launch edge that follows the command
    task automatic sedge(input logic v);
        bit done_before;
        done_before = cmd_done;
        sclk = v;
        if (v == !ices) begin
            samp_cnt++;
            if (samp_cnt == 8) cmd_done = 1'b1;
        end
        tick(6);
        if (done_before && (v == oces)) begin
            rx_bit.push_back(sdo_d);
            rx_oe.push_back(sdo_oe);
        end
        tick(H - 6);
    endtask

    task automatic sbit(input logic b);
        sdi = b;
        sedge(1'b1);
        sedge(1'b0);
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nbits);
        rx_bit.delete();
        rx_oe.delete();
        samp_cnt = 0;
        cmd_done = 1'b0;
        cs_n = 1'b0;
        tick(H);
        for (int i = 0; i < 8; i++) sbit(cmd[i]);
        for (int k = 0; k < nbits; k++) sbit(wbuf[k / 8][k % 8]);
        tick(H);
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    function automatic logic [7:0] wr_cmd(input logic [4:0] a, input logic b);
        return {b, 1'b0, a, 1'b0};
    endfunction

    function automatic logic [7:0] rd_cmd(input logic [4:0] a, input logic b);
        return {b, 1'b0, a, 1'b1};
    endfunction

    // compare received bytes to the model, then require the output off afterwards
    task automatic check_rx(input string tag, input int start, input int nbytes);
        int need;
        int ones;
        need = 8 * nbytes + 1;
        chk({tag, " launch count"}, 32'(rx_bit.size() >= need), 32'd1);
        if (rx_bit.size() >= need) begin
            ones = 0;
            for (int j = 0; j < nbytes; j++) begin
                logic [7:0] v;
                for (int b = 0; b < 8; b++) begin
                    v[b] = rx_bit[8 * j + b];
                    if (rx_oe[8 * j + b] === 1'b1) ones++;
                end
                chk({tag, " data byte"}, 32'(v), 32'(exp_regs[start + j]));
            end
            chk({tag, " enable while driving"}, 32'(ones), 32'(8 * nbytes));
            ones = 0;
            for (int k = 8 * nbytes; k < rx_oe.size(); k++)
                if (rx_oe[k] !== 1'b0) ones++;
            chk({tag, " off after last byte"}, 32'(ones), 32'd0);
        end
    endtask

    task automatic lcl_chk(input string tag, input int a);
        lcl_addr = AW'(a);
        tick(1);
        chk(tag, 32'(lcl_rdata), 32'(exp_regs[a]));
    endtask

    // per-clock model of the output enable: off while chip select idles or a command is ignored
    always @(negedge clk) begin
        if (cs_n) cs_hi_cnt++;
        else      cs_hi_cnt = 0;
        if (rst_n && cs_hi_cnt >= 4) chk("R1 idle output off", 32'(sdo_oe), 32'd0);
        if (quiet_mode) chk("R11 reserved command keeps output off", 32'(sdo_oe), 32'd0);
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = '0;
        for (int i = 0; i < 32; i++) wbuf[i] = '0;
        tick(6);
        rst_n = 1'b1;
        tick(4);

        // R13: reset state
        chk("R13 output off after reset", 32'(sdo_oe), 32'd0);
        lcl_chk("R13 reset register 0", 0);
        lcl_chk("R13 reset register 31", 31);

        // R2, R3: single write, neighbours untouched
        wbuf[0] = 8'hA5;
        xfer(wr_cmd(5'd5, 1'b0), 8);
        exp_regs[5] = 8'hA5;
        lcl_chk("R3 single write", 5);
        lcl_chk("R2 address decode lower neighbour", 4);
        lcl_chk("R2 address decode upper neighbour", 6);

        // R4: single read
        xfer(rd_cmd(5'd5, 1'b0), 16);
        check_rx("R4 single read", 5, 1);

        // R5, R6: every pairing of capture and launch edges
        for (int m = 0; m < 4; m++) begin
            ices = m[0];
            oces = m[1];
            wbuf[0] = 8'h3C ^ 8'(m * 8'h51);
            xfer(wr_cmd(5'(8 + m), 1'b0), 8);
            exp_regs[8 + m] = wbuf[0];
            lcl_chk("R5 capture edge write", 8 + m);
            xfer(rd_cmd(5'(8 + m), 1'b0), 16);
            check_rx("R6 launch edge read", 8 + m, 1);
        end
        ices = 1'b0;
        oces = 1'b0;

        // R8: burst write with nonzero address field, one byte past the limit
        for (int j = 0; j < 24; j++) wbuf[j] = 8'h40 + 8'(j);
        xfer(wr_cmd(5'h1F, 1'b1), 24 * 8);
        for (int j = 0; j < 23; j++) exp_regs[j] = 8'h40 + 8'(j);
        lcl_chk("R8 burst write first", 0);
        lcl_chk("R8 burst write middle", 11);
        lcl_chk("R8 burst write last", 22);
        lcl_chk("R8 burst write overrun ignored", 23);

        // R7: burst read with nonzero address field, mixed edges
        ices = 1'b1;
        xfer(rd_cmd(5'h0A, 1'b1), 22 * 8 + 16);
        check_rx("R7 burst read", 0, 22);
        ices = 1'b0;

        // R9: extra byte in a single write and extra clocks in a single read
        wbuf[0] = 8'h77;
        wbuf[1] = 8'h99;
        xfer(wr_cmd(5'd3, 1'b0), 16);
        exp_regs[3] = 8'h77;
        lcl_chk("R9 single write stored", 3);
        lcl_chk("R9 next register untouched", 4);
        xfer(rd_cmd(5'd3, 1'b0), 32);
        check_rx("R9 single read extra clocks", 3, 1);

        // R10: partial byte cut off; R1: aborted read
        wbuf[0] = 8'hFF;
        xfer(wr_cmd(5'd3, 1'b0), 5);
        lcl_chk("R10 partial write ignored", 3);
        xfer(rd_cmd(5'd3, 1'b0), 4);
        xfer(rd_cmd(5'd3, 1'b0), 16);
        check_rx("R1 read after aborted read", 3, 1);

        // R11: reserved bit set on write and on read
        quiet_mode = 1'b1;
        wbuf[0] = 8'h5A;
        xfer(wr_cmd(5'd3, 1'b0) | 8'h40, 8);
        xfer(rd_cmd(5'd3, 1'b0) | 8'h40, 16);
        quiet_mode = 1'b0;
        lcl_chk("R11 reserved write ignored", 3);

        // R12: local port shows every register
        for (int i = 0; i < NREG; i++) lcl_chk("R12 local read port", i);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule